// File: doc/BRIEF.md
# Soft Reset and Clock-Gate Sequencer

This block is the control front end that places a peripheral into soft reset and stops its clock. Software sees a single control word that holds a reset-request bit, a clock-gate bit and a field of configuration bits. The word can be written in three ways: it can be overwritten whole, ones can be OR-ed into it, or ones can be masked out of it. A sibling configuration register sits next to the word. A one-cycle registered read port returns either the control word or the sibling register.

Setting the reset bit has two effects. It drives the synchronous child reset output high at once. A fixed number of cycles later, which gives in-flight child activity time to drain, the block gates the child clock and the gate bit reads back as 1. Clearing the reset bit releases the child reset on the next edge, but the clock stays gated. Software must then clear the gate bit as a separate step to start the child clock again. The block drives only the gated-clock enable and the child reset. The gating cell and the child logic sit outside it.

Top module: `srst_cg_seq`

## Requirements
- R1: A write with `wr_addr` 0 replaces the control word with `wr_data`. Address 1 ORs `wr_data` into the word. Address 2 clears every bit of the word that is 1 in `wr_data`. Address 3 replaces the sibling register. `rd_data` shows the control word when `rd_sel` is 0 and the sibling register when it is 1, one clock after the selection and the register state it reflects.
- R2: In the control word, bit DW-1 is the reset request, bit DW-2 is the clock-gate bit, and bits DW-3..0 are the configuration field.
- R3: After power-on reset, the reset bit reads 0 and the gate bit reads 1. `clk_en_o` and `child_rst_o` are both 0. The configuration field holds CFG_DEF and the sibling register holds SIB_DEF.
- R4: When the reset bit goes from 0 to 1, `child_rst_o` is 1 after the next clock edge.
- R5: The gate bit becomes 1 and `clk_en_o` becomes 0 exactly DRAIN_CYC edges (4 by default) after the edge that set the reset bit.
- R6: Clearing the reset bit drops it and `child_rst_o` on the next edge. The gate bit stays 1 and `clk_en_o` stays 0.
- R7: Clearing the gate bit sets `clk_en_o` to 1 on the next edge, and the gate bit reads 0.
- R8: While the reset bit is 1, the configuration field reads CFG_DEF and the sibling register reads SIB_DEF. Writes to either of them are discarded.
- R9: A set or clear on a bit that is already in the requested state has no effect. In particular, setting the reset bit again does not restart the drain interval.
- R10: If a software clear of the gate bit arrives on the same edge as the end of the drain interval, the drain wins and the gate bit becomes 1.
- R11: Software can set the gate bit without the reset bit. This drops `clk_en_o` on the next edge and leaves `child_rst_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| wr_addr | input | 2 | 0 plain, 1 set-bits, 2 clear-bits, 3 sibling write |
| wr_data | input | DW | Write data or bit mask |
| rd_sel | input | 1 | 0 control word, 1 sibling register |
| rd_data | output | DW | Registered read data |
| clk_en_o | output | 1 | Enable for the child clock-gating cell |
| child_rst_o | output | 1 | Synchronous reset to the child logic |

## Verification
The bench builds the block with DW=16 and DRAIN_CYC=5 rather than the default 4. The longer interval leaves room between the first set of the reset bit and the point where the clock gates, so a repeated set can be placed inside it: had the interval restarted, the clock would still be running at the expected gating edge. The same setting is used to place a gate-clear write exactly on the drain-expiry edge. It also lets the bench confirm that the gating edge follows the parameter, not a fixed count.

// File: rtl/srst_pkg.sv
package srst_pkg;

  // Write address decode for the control front end
  typedef enum logic [1:0] {
    WA_CTRL = 2'd0,
    WA_SET  = 2'd1,
    WA_CLR  = 2'd2,
    WA_SIB  = 2'd3
  } wr_addr_e;

endpackage

// File: rtl/srst_drain_timer.sv
module srst_drain_timer #(
  parameter int DRAIN_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic expire
);

  logic active;

  generate
    if (DRAIN_CYC > 1) begin : g_count
      localparam int CNT_W = $clog2(DRAIN_CYC);
      localparam logic [CNT_W-1:0] LOAD = CNT_W'(DRAIN_CYC - 1);
      logic [CNT_W-1:0] cnt;

      assign expire = active && (cnt == '0);

      always_ff @(posedge clk) begin
        if (rst) begin
          active <= 1'b0;
          cnt    <= '0;
        end else if (start) begin
          active <= 1'b1;
          cnt    <= LOAD;
        end else if (expire) begin
          active <= 1'b0;
        end else if (active) begin
          cnt    <= cnt - 1'b1;
        end
      end

      AST_DRAIN_LOAD: assert property (@(posedge clk) disable iff (rst)
        start |=> (active && cnt == LOAD)); // R5
    end else begin : g_single
      assign expire = active;

      always_ff @(posedge clk) begin
        if (rst)         active <= 1'b0;
        else if (start)  active <= 1'b1;
        else if (expire) active <= 1'b0;
      end
    end
  endgenerate

  AST_DRAIN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (expire && !start) |=> !active); // R9

endmodule

// File: rtl/srst_regbank.sv
module srst_regbank
  import srst_pkg::*;
#(
  parameter int DW = 16,
  parameter logic [DW-3:0] CFG_DEF = '0,
  parameter logic [DW-1:0] SIB_DEF = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  wr_addr_e      wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          hw_gate_set,
  output logic          rst_bit_q,
  output logic          gate_bit_q,
  output logic [DW-3:0] cfg_q,
  output logic [DW-1:0] sib_q,
  output logic          rst_rise,
  output logic          clk_en_q
);

  localparam int RST_POS  = DW - 1;
  localparam int GATE_POS = DW - 2;
  localparam int CFG_W    = DW - 2;

  logic [DW-1:0]    ctrl_cur;
  logic [DW-1:0]    ctrl_wr;
  logic             rst_n;
  logic             gate_n;
  logic [CFG_W-1:0] cfg_n;
  logic [DW-1:0]    sib_n;

  assign ctrl_cur = {rst_bit_q, gate_bit_q, cfg_q};

  always_comb begin
    ctrl_wr = ctrl_cur;
    if (wr_en) begin
      case (wr_addr)
        WA_CTRL: ctrl_wr = wr_data;
        WA_SET:  ctrl_wr = ctrl_cur | wr_data;
        WA_CLR:  ctrl_wr = ctrl_cur & ~wr_data;
        default: ctrl_wr = ctrl_cur;
      endcase
    end
  end

  always_comb begin
    rst_n    = ctrl_wr[RST_POS];
    gate_n   = hw_gate_set | ctrl_wr[GATE_POS];
    cfg_n    = rst_n ? CFG_DEF : ctrl_wr[CFG_W-1:0];
    sib_n    = sib_q;
    if (rst_n)
      sib_n = SIB_DEF;
    else if (wr_en && wr_addr == WA_SIB)
      sib_n = wr_data;
    rst_rise = rst_n & ~rst_bit_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_bit_q  <= 1'b0;
      gate_bit_q <= 1'b1;
      cfg_q      <= CFG_DEF;
      sib_q      <= SIB_DEF;
      clk_en_q   <= 1'b0;
    end else begin
      rst_bit_q  <= rst_n;
      gate_bit_q <= gate_n;
      cfg_q      <= cfg_n;
      sib_q      <= sib_n;
      clk_en_q   <= ~gate_n;
    end
  end

  AST_CLR_RST_FAST: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == WA_CLR && wr_data[RST_POS]) |=> !rst_bit_q); // R6

  AST_CFG_DEFAULT: assert property (@(posedge clk) disable iff (rst)
    rst_bit_q |-> (cfg_q == CFG_DEF && sib_q == SIB_DEF)); // R8

  AST_GATE_SET: assert property (@(posedge clk) disable iff (rst)
    hw_gate_set |=> (gate_bit_q && !clk_en_q)); // R10

endmodule

// File: rtl/srst_readback.sv
module srst_readback #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_sel,
  input  logic [DW-1:0] ctrl_word,
  input  logic [DW-1:0] sib_word,
  output logic [DW-1:0] rd_data_q
);

  always_ff @(posedge clk) begin
    if (rst)         rd_data_q <= '0;
    else if (rd_sel) rd_data_q <= sib_word;
    else             rd_data_q <= ctrl_word;
  end

endmodule

// File: rtl/srst_cg_seq.sv
module srst_cg_seq
  import srst_pkg::*;
#(
  parameter int DW        = 16,
  parameter int DRAIN_CYC = 4,
  parameter logic [DW-3:0] CFG_DEF = (DW-2)'(65),
  parameter logic [DW-1:0] SIB_DEF = DW'(255)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_sel,
  output logic [DW-1:0] rd_data,
  output logic          clk_en_o,
  output logic          child_rst_o
);

  logic          rst_bit;
  logic          gate_bit;
  logic [DW-3:0] cfg;
  logic [DW-1:0] sib;
  logic          rst_rise;
  logic          drain_done;
  logic          clk_en_q;

  srst_regbank #(
    .DW      (DW),
    .CFG_DEF (CFG_DEF),
    .SIB_DEF (SIB_DEF)
  ) u_regbank (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr_e'(wr_addr)),
    .wr_data     (wr_data),
    .hw_gate_set (drain_done),
    .rst_bit_q   (rst_bit),
    .gate_bit_q  (gate_bit),
    .cfg_q       (cfg),
    .sib_q       (sib),
    .rst_rise    (rst_rise),
    .clk_en_q    (clk_en_q)
  );

  srst_drain_timer #(
    .DRAIN_CYC (DRAIN_CYC)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .start  (rst_rise),
    .expire (drain_done)
  );

  srst_readback #(
    .DW (DW)
  ) u_readback (
    .clk       (clk),
    .rst       (rst),
    .rd_sel    (rd_sel),
    .ctrl_word ({rst_bit, gate_bit, cfg}),
    .sib_word  (sib),
    .rd_data_q (rd_data)
  );

  assign clk_en_o    = clk_en_q;
  assign child_rst_o = rst_bit;

  AST_CLKEN_TRACK: assert property (@(posedge clk) disable iff (rst)
    clk_en_o != gate_bit); // R7

  AST_RISE_STARTS_RESET: assert property (@(posedge clk) disable iff (rst)
    rst_rise |=> child_rst_o); // R4

endmodule

// File: tb/srst_cg_seq_bench.sv
`timescale 1ns/1ps
module srst_cg_seq_bench;

  localparam int DW = 16;
  localparam int D  = 5;
  localparam logic [DW-3:0] CDEF   = 14'h0041;
  localparam logic [DW-1:0] SDEF   = 16'h00FF;
  localparam logic [DW-1:0] B_RST  = 16'h8000;
  localparam logic [DW-1:0] B_GATE = 16'h4000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = 2'd0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_sel = 1'b0;
  logic [DW-1:0] rd_data;
  logic          clk_en_o;
  logic          child_rst_o;

  always #2.5 clk = ~clk;

  srst_cg_seq #(
    .DW        (DW),
    .DRAIN_CYC (D),
    .CFG_DEF   (CDEF),
    .SIB_DEF   (SDEF)
  ) u_srst_cg_seq (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_sel      (rd_sel),
    .rd_data     (rd_data),
    .clk_en_o    (clk_en_o),
    .child_rst_o (child_rst_o)
  );

  typedef struct {
    int            req;
    bit            chk_rd;
    logic [DW-1:0] rd;
    logic          ce;
    logic          cr;
  } exp_t;

  exp_t q[$];
  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  function automatic logic [DW-1:0] w(logic r, logic g, logic [DW-3:0] c);
    return {r, g, c};
  endfunction

  task automatic expect_now(int req, bit chk_rd, logic [DW-1:0] rd, logic ce, logic cr);
    exp_t e;
    e.req = req; e.chk_rd = chk_rd; e.rd = rd; e.ce = ce; e.cr = cr;
    q.push_back(e);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_run++;
        if (clk_en_o !== e.ce || child_rst_o !== e.cr || (e.chk_rd && rd_data !== e.rd)) begin
          n_fail++;
          $display("FAIL R%0d: clk_en=%0b child_rst=%0b rd=%h, expected clk_en=%0b child_rst=%0b rd=%h%s",
                   e.req, clk_en_o, child_rst_o, rd_data, e.ce, e.cr, e.rd,
                   e.chk_rd ? "" : " (rd not checked)");
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expect_now(3, 0, '0, 0, 0);                          // R3 outputs
    step(); expect_now(3, 1, w(0, 1, CDEF), 0, 0);       // R3 R2 control word
    rd_sel = 1'b1;
    step(); expect_now(3, 1, SDEF, 0, 0);                // R3 sibling default
    rd_sel = 1'b0;

    wr(2'd0, w(0, 0, 14'h1234)); expect_now(7, 0, '0, 1, 0);     // R7 plain write ungates
    step(); expect_now(1, 1, w(0, 0, 14'h1234), 1, 0);          // R1 plain
    wr(2'd1, 16'h0005); step(); expect_now(1, 1, 16'h1235, 1, 0); // R1 set alias
    wr(2'd2, 16'h0030); step(); expect_now(1, 1, 16'h1205, 1, 0); // R1 clear alias
    wr(2'd3, 16'hA5C3); rd_sel = 1'b1;
    step(); expect_now(1, 1, 16'hA5C3, 1, 0);                   // R1 sibling
    rd_sel = 1'b0;
    step(); expect_now(1, 1, 16'h1205, 1, 0);                   // R1 ctrl untouched

    wr(2'd1, B_GATE); expect_now(11, 0, '0, 0, 0);              // R11
    step(); expect_now(11, 1, w(0, 1, 14'h1205), 0, 0);         // R11 R2
    wr(2'd2, B_GATE); expect_now(7, 0, '0, 1, 0);               // R7
    step(); expect_now(7, 1, 16'h1205, 1, 0);                   // R7

    wr(2'd1, B_RST); expect_now(4, 0, '0, 1, 1);                // R4
    for (int i = 1; i < D; i++) begin
      step(); expect_now(5, 0, '0, 1, 1);                       // R5 still draining
    end
    step(); expect_now(5, 0, '0, 0, 1);                         // R5 gated
    step(); expect_now(8, 1, w(1, 1, CDEF), 0, 1);              // R8 R5 readback

    wr(2'd0, 16'hFFFF); step(); expect_now(8, 1, w(1, 1, CDEF), 0, 1); // R8
    wr(2'd3, 16'h1111); rd_sel = 1'b1;
    step(); expect_now(8, 1, SDEF, 0, 1);                       // R8 sibling
    rd_sel = 1'b0;

    wr(2'd2, B_RST); expect_now(6, 0, '0, 0, 0);                // R6
    step(); expect_now(6, 1, w(0, 1, CDEF), 0, 0);              // R6 gate kept
    wr(2'd2, B_GATE); expect_now(7, 0, '0, 1, 0);               // R7
    step(); expect_now(7, 1, w(0, 0, CDEF), 1, 0);              // R7

    wr(2'd1, B_RST); step(); step();
    wr(2'd1, B_RST); expect_now(9, 0, '0, 1, 1);                // R9 repeat set
    for (int i = 4; i < D; i++) begin
      step(); expect_now(9, 0, '0, 1, 1);                       // R9
    end
    step(); expect_now(9, 0, '0, 0, 1);                         // R9 original timing
    wr(2'd2, B_RST | B_GATE); expect_now(9, 0, '0, 1, 0);       // R6 R7
    wr(2'd2, B_RST); expect_now(9, 0, '0, 1, 0);                // R9 no-op clear
    step(); expect_now(9, 1, w(0, 0, CDEF), 1, 0);              // R9

    wr(2'd1, B_RST);
    repeat (D - 1) step();
    wr(2'd2, B_GATE); expect_now(10, 0, '0, 0, 1);              // R10
    step(); expect_now(10, 1, w(1, 1, CDEF), 0, 1);             // R10
    wr(2'd2, B_RST | B_GATE); expect_now(6, 0, '0, 1, 0);       // R6

    step(); step();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule